// File: doc/BRIEF.md
# Fixed-Point Activation Unit (Hard Sigmoid and Tanh)

This block applies one of two neural-network activation functions to a signed Q4.12 operand and returns a Q4.12 result. A single select bit, sampled when the operand is accepted, chooses the function. The first is a clamped linear hard sigmoid that needs only one constant multiply and one add. The second is a hyperbolic tangent. It evaluates e^|x| and e^-|x| once each and keeps both in registers. It then divides their difference by their sum with a restoring divider that produces one quotient bit per clock.

Operands enter through a valid/ready handshake and results leave through another. Only one operation is in flight at a time. The hard sigmoid and a saturated tanh answer in the cycle after acceptance. A tanh inside the working range takes a fixed number of cycles. Each exponential is formed by range reduction: the integer part and the upper fraction bits each index a small table that is computed at elaboration, and the remaining fraction bits apply a first-order correction. The tanh is computed on the magnitude of the operand and the sign is applied at the end, so the function is odd bit for bit.

Top module: `act_unit`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: An operand is taken on a clock edge where in_valid and in_ready are both 1. in_ready stays 0 while an operation is in progress or a result is waiting. out_valid and out_y hold steady until a clock edge where out_ready is 1.
- R3: in_func = 0 selects the hard sigmoid and in_func = 1 selects tanh. in_func and in_x are sampled only at acceptance, so later changes do not alter the result.
- R4: Hard sigmoid with x <= -10240 (-2.5) returns 0.
- R5: Hard sigmoid with x >= 10240 (+2.5) returns 4096 (1.0).
- R6: Hard sigmoid with -10240 < x < 10240 returns 2048 + floor(x * 13107 / 65536), where 13107 stands for the slope 0.2 in 16 fractional bits.
- R7: A hard-sigmoid result is visible in the cycle after the accepting edge.
- R8: Tanh with |x| >= 16384 (4.0) returns +4096 for positive x and -4096 for negative x, also visible in the cycle after the accepting edge. This includes x = -32768.
- R9: Tanh with |x| < 16384 lies within 16 LSB of the true tanh, and its magnitude is at most 4095.
- R10: A non-saturated tanh result becomes visible after 16 clock edges, counting the accepting edge as the first: 4 control edges plus 12 quotient bits.
- R11: Tanh is odd bit-exactly: the result for -x equals the negated result for x, and tanh(0) = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Block can take an operand |
| in_func | input | 1 | 0 hard sigmoid, 1 tanh |
| in_x | input | 16 | Signed Q4.12 operand |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_y | output | 16 | Signed Q4.12 result |

## Verification
The hard sigmoid is driven on both sides of each knee, exactly at ±2.5, and at interior points of both signs. This separates an off-by-one clamp comparison from an error in the slope or the rounding. The tanh is driven with zero, one LSB, mid-range values and the largest unsaturated magnitude, which exposes errors in the exponential tables, the correction term and the divider. Mirrored operand pairs show whether the sign restoration is exact. Operands at and beyond ±4.0, including the most negative code, exercise the saturation bypass and its short latency. Holding out_ready low while changing in_func and in_x shows whether the result stays held and whether it depends only on the values present at acceptance.

// File: rtl/act_pkg.sv
package act_pkg;
  localparam int XW    = 16;            // operand / result width
  localparam int FRAC  = 12;            // fractional bits of operand
  localparam int ONE   = 1 << FRAC;     // 1.0 in Q4.12
  localparam int MAGW  = FRAC + 2;      // magnitude bits below the 4.0 saturation point
  localparam int TBLF  = 16;            // fractional bits of exponential values
  localparam int EW    = TBLF + 6;      // e^4 < 64 needs six integer bits
  localparam int DW    = EW + 1;        // sum of two exponentials
  localparam int FHB   = 4;             // upper fraction bits used as a table index

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXP,
    ST_START,
    ST_WAIT
  } act_state_e;
endpackage

// File: rtl/act_hsig.sv
module act_hsig
  import act_pkg::*;
(
  input  logic signed [XW-1:0] x,
  output logic        [XW-1:0] y
);
  localparam int XP = XW + 18;
  localparam logic signed [17:0] SLOPE = 18'((1 << 16) / 5);   // 0.2 in 16 fraction bits
  localparam logic signed [XW-1:0] KNEE = XW'(5 << (FRAC - 1)); // 2.5

  logic signed [XP-1:0] prod;
  logic signed [XP-1:0] lin;

  assign prod = XP'(x) * XP'(SLOPE);
  assign lin  = prod >>> 16;

  always_comb begin
    if (x <= -KNEE)     y = '0;
    else if (x >= KNEE) y = XW'(ONE);
    else                y = XW'(ONE / 2) + XW'(lin);
  end
endmodule

// File: rtl/act_exp.sv
module act_exp
  import act_pkg::*;
#(
  parameter bit NEG = 1'b0
) (
  input  logic [MAGW-1:0] mag,
  output logic [EW-1:0]   e
);
  localparam int NI  = 1 << (MAGW - FRAC);
  localparam int NF  = 1 << FHB;
  localparam int LW  = FRAC - FHB;
  localparam int TNW = TBLF + 5;
  localparam int TFW = TBLF + 2;
  localparam int P1W = TNW + TFW;
  localparam int P2W = EW + FRAC + 1;
  localparam real SGN   = NEG ? -1.0 : 1.0;
  localparam real SCALE = real'(1 << TBLF);

  logic [TNW-1:0] tn [NI];
  logic [TFW-1:0] tf [NF];

  for (genvar g = 0; g < NI; g++) begin : g_tn
    assign tn[g] = TNW'($rtoi($exp(SGN * real'(g)) * SCALE + 0.5));
  end
  for (genvar g = 0; g < NF; g++) begin : g_tf
    assign tf[g] = TFW'($rtoi($exp(SGN * real'(g) / real'(NF)) * SCALE + 0.5));
  end

  logic [MAGW-FRAC-1:0] idx_n;
  logic [FHB-1:0]       idx_f;
  logic [LW-1:0]        low;
  logic [P1W-1:0]       p1;
  logic [EW-1:0]        p;
  logic [FRAC:0]        corr;
  logic [P2W-1:0]       p2;

  assign idx_n = mag[MAGW-1:FRAC];
  assign idx_f = mag[FRAC-1 -: FHB];
  assign low   = mag[LW-1:0];
  assign p1    = P1W'(tn[idx_n]) * P1W'(tf[idx_f]);
  assign p     = EW'(p1 >> TBLF);
  assign corr  = NEG ? (FRAC+1)'(ONE) - (FRAC+1)'(low) : (FRAC+1)'(ONE) + (FRAC+1)'(low);
  assign p2    = P2W'(p) * P2W'(corr);
  assign e     = EW'(p2 >> FRAC);
endmodule

// File: rtl/act_div.sv
module act_div
  import act_pkg::*;
#(
  parameter int NW = EW,
  parameter int QW = FRAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [QW-1:0] quo,
  output logic          done
);
  localparam int CW = $clog2(QW + 1);

  logic [DW-1:0] rem_q, rem_d, den_q, den_d;
  logic [QW-1:0] quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, done_q, done_d;
  logic [DW:0]   shifted, trial;

  assign shifted = {rem_q, 1'b0};
  assign trial   = shifted - {1'b0, den_q};

  always_comb begin
    rem_d  = rem_q;
    den_d  = den_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      rem_d  = DW'(num);
      den_d  = den;
      quo_d  = '0;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (!trial[DW]) begin
        rem_d = trial[DW-1:0];
        quo_d = {quo_q[QW-2:0], 1'b1};
      end else begin
        rem_d = shifted[DW-1:0];
        quo_d = {quo_q[QW-2:0], 1'b0};
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(QW - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      den_q  <= den_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign quo  = quo_q;
  assign done = done_q;

  // R9: the partial remainder never reaches the divisor
  a_r9_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < den_q));
endmodule

// File: rtl/act_unit.sv
module act_unit
  import act_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_func,
  input  logic [XW-1:0] in_x,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [XW-1:0] out_y
);
  localparam logic [XW:0] SAT_LIM = (XW+1)'(1 << MAGW);
  localparam logic signed [XW-1:0] POS1 = XW'(ONE);
  localparam logic signed [XW-1:0] NEG1 = -XW'(ONE);

  act_state_e    state_q, state_d;
  logic          kind_q, kind_d, neg_q, neg_d, ov_q, ov_d;
  logic [MAGW-1:0] mag_q, mag_d;
  logic [EW-1:0] a_q, a_d, b_q, b_d;
  logic [XW-1:0] y_q, y_d;

  logic          accept, sat, div_start, div_done;
  logic signed [XW:0] xs;
  logic [XW:0]   mag_w;
  logic [XW-1:0] sig_y, q_ext;
  logic [FRAC-1:0] quo;
  logic [EW-1:0] exp_res [2];

  assign in_ready = (state_q == ST_IDLE) && !ov_q;
  assign accept   = in_valid && in_ready;
  assign xs       = (XW+1)'($signed(in_x));
  assign mag_w    = xs[XW] ? (XW+1)'(-xs) : (XW+1)'(xs);
  assign sat      = mag_w >= SAT_LIM;
  assign div_start = (state_q == ST_START);
  assign q_ext    = XW'(quo);

  act_hsig u_hsig (.x($signed(in_x)), .y(sig_y));

  for (genvar g = 0; g < 2; g++) begin : g_exp
    act_exp #(.NEG(g == 1)) u_exp (.mag(mag_q), .e(exp_res[g]));
  end

  act_div #(.NW(EW), .QW(FRAC)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(a_q - b_q), .den(DW'(a_q) + DW'(b_q)),
    .quo(quo), .done(div_done)
  );

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    neg_d   = neg_q;
    mag_d   = mag_q;
    a_d     = a_q;
    b_d     = b_q;
    y_d     = y_q;
    ov_d    = ov_q;
    if (ov_q && out_ready) ov_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          kind_d = in_func;
          if (!in_func) begin
            y_d  = sig_y;
            ov_d = 1'b1;
          end else if (sat) begin
            y_d  = xs[XW] ? NEG1 : POS1;
            ov_d = 1'b1;
          end else begin
            neg_d   = xs[XW];
            mag_d   = mag_w[MAGW-1:0];
            state_d = ST_EXP;
          end
        end
      end
      ST_EXP: begin
        a_d     = exp_res[0];
        b_d     = exp_res[1];
        state_d = ST_START;
      end
      ST_START: state_d = ST_WAIT;
      ST_WAIT: begin
        if (div_done) begin
          y_d     = neg_q ? -q_ext : q_ext;
          ov_d    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= 1'b0;
      neg_q   <= 1'b0;
      mag_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      y_q     <= '0;
      ov_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      neg_q   <= neg_d;
      mag_q   <= mag_d;
      a_q     <= a_d;
      b_q     <= b_d;
      y_q     <= y_d;
      ov_q    <= ov_d;
    end
  end

  assign out_valid = ov_q;
  assign out_y     = y_q;

  // R2: a held result does not change until taken
  a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y)));
  // R2: no new operand while work is pending
  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !in_ready);
  // R7: hard sigmoid answers on the next edge
  a_r7_sig_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_func) |=> out_valid);
  // R8: saturated tanh bypasses the divider
  a_r8_sat_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_func && sat) |=> (out_valid && state_q == ST_IDLE));
  // R6: sigmoid output stays in [0, 1.0]
  a_r6_sig_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !kind_q) |-> ($signed(out_y) >= 0 && $signed(out_y) <= POS1));
  // R9: tanh output stays in [-1.0, 1.0]
  a_r9_tanh_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && kind_q) |-> ($signed(out_y) >= NEG1 && $signed(out_y) <= POS1));
  // R9: stored e^|x| never below e^-|x|
  a_r9_exp_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START) |-> (a_q >= b_q && b_q != '0));
endmodule

// File: tb/act_unit_test.sv
`timescale 1ns/1ps
module act_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_func = 1'b0;
  logic [15:0] in_x = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid;
  logic [15:0] out_y;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  act_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_func(in_func), .in_x(in_x), .out_valid(out_valid),
    .out_ready(out_ready), .out_y(out_y)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_near(string req, int act, int exp, int tol);
    n_chk++;
    if (act > exp + tol || act < exp - tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (+/-%0d)", req, act, exp, tol);
    end
  endtask

  task automatic send(bit f, logic [15:0] x);
    @(negedge clk);
    in_valid = 1'b1; in_func = f; in_x = x;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    in_valid = 1'b0; in_func = !f; in_x = ~x;
  endtask

  task automatic wait_res(output logic signed [15:0] y);
    while (!out_valid && lat < 64) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    y = out_y;
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_op(bit f, logic signed [15:0] x, output logic signed [15:0] y);
    send(f, x);
    wait_res(y);
    take();
  endtask

  function automatic int sig_ref(int x);
    if (x <= -10240) return 0;
    if (x >= 10240) return 4096;
    return 2048 + ((x * 13107) >>> 16);
  endfunction

  function automatic int tanh_ref(int x);
    return $rtoi($tanh(real'(x) / 4096.0) * 4096.0 + (x >= 0 ? 0.5 : -0.5));
  endfunction

  task automatic t_reset();
    chk("R1 in_ready after reset", int'(in_ready), 1);
    chk("R1 out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_sig_clamp();
    logic signed [15:0] y;
    int xs [4] = '{-10240, -10241, -32768, -20000};
    foreach (xs[i]) begin
      run_op(1'b0, 16'(xs[i]), y);
      chk("R4 sigmoid low clamp", int'(y), 0);
      chk("R7 sigmoid latency", lat, 1);
    end
    run_op(1'b0, 16'sd10240, y);
    chk("R5 sigmoid high clamp at knee", int'(y), 4096);
    run_op(1'b0, 16'sd32767, y);
    chk("R5 sigmoid high clamp max", int'(y), 4096);
  endtask

  task automatic t_sig_linear();
    logic signed [15:0] y;
    int xs [7] = '{0, 1, -1, 10239, -10239, 4096, -5000};
    foreach (xs[i]) begin
      run_op(1'b0, 16'(xs[i]), y);
      chk("R6 sigmoid linear segment", int'(y), sig_ref(xs[i]));
    end
  endtask

  task automatic t_tanh_sat();
    logic signed [15:0] y;
    int xs [5] = '{16384, -16384, 32767, -32768, 20000};
    foreach (xs[i]) begin
      run_op(1'b1, 16'(xs[i]), y);
      chk("R8 tanh saturation", int'(y), xs[i] > 0 ? 4096 : -4096);
      chk("R8 saturation latency", lat, 1);
    end
  endtask

  task automatic t_tanh_accuracy();
    logic signed [15:0] y;
    int xs [8] = '{1, 2048, 4096, 8192, 12000, 16383, -6963, -300};
    foreach (xs[i]) begin
      run_op(1'b1, 16'(xs[i]), y);
      chk_near("R9 tanh accuracy", int'(y), tanh_ref(xs[i]), 16);
      chk("R9 tanh magnitude below one", int'(y > 16'sd4095 || y < -16'sd4095), 0);
      chk("R10 tanh latency", lat, 16);
    end
  endtask

  task automatic t_tanh_odd();
    logic signed [15:0] yp, yn;
    int xs [6] = '{100, 4095, 8000, 12345, 16383, 777};
    run_op(1'b1, 16'sd0, yp);
    chk("R11 tanh of zero", int'(yp), 0);
    foreach (xs[i]) begin
      run_op(1'b1, 16'(xs[i]), yp);
      run_op(1'b1, 16'(-xs[i]), yn);
      chk("R11 tanh odd symmetry", int'(yn), -int'(yp));
    end
  endtask

  task automatic t_hold();
    logic signed [15:0] y0;
    logic signed [15:0] y1;
    send(1'b1, 16'sd6000);
    wait_res(y0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_func = 1'b0; in_x = 16'h8000; in_valid = 1'b1;
    end
    chk("R2 out_valid held", int'(out_valid), 1);
    chk("R2 out_y held", int'(out_y), int'(y0));
    chk("R2 in_ready low while result waits", int'(in_ready), 0);
    in_valid = 1'b0;
    take();
    chk("R2 out_valid cleared after take", int'(out_valid), 0);
    chk_near("R3 tanh selected at acceptance", int'(y0), tanh_ref(6000), 16);
    send(1'b0, 16'sd2000);
    chk("R2 in_ready low during no-op", int'(in_ready), 0);
    wait_res(y1);
    take();
    chk("R3 sigmoid selected at acceptance", int'(y1), sig_ref(2000));
    send(1'b1, 16'sd3000);
    chk("R2 in_ready low while tanh runs", int'(in_ready), 0);
    wait_res(y1);
    take();
    chk_near("R3 later input change ignored", int'(y1), tanh_ref(3000), 16);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sig_clamp();
    t_sig_linear();
    t_tanh_sat();
    t_tanh_accuracy();
    t_tanh_odd();
    t_hold();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule